// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a clocked, synthesizable stand-in for an asynchronous static memory with sixteen-bit words. It keeps the active-low control set of such a part: chip select, output enable, write strobe, and a separate enable for each byte lane. An external agent drives these pins as it would drive the real device. A fast reference clock samples them, and a write goes into the array only when the sampler sees the write pulse end.

A read is combinational. The addressed word is always present on the read data bus. A two-bit drive-enable vector stands in for the three-state output buffers and marks which byte lanes the core would drive. A write commits at the first clock edge that sees either chip select or write strobe high after a sample in which both were low. It stores the address, data and lane enables that were sampled in the last cycle of the pulse. A standby flag follows chip select.

The full-size part has 32,768 words and a fifteen-bit address (AddrW = 15). The default build uses a smaller array so that elaboration stays light. The behaviour is the same for any AddrW.

Top module: `byte_lane_sram`

## Requirements
- R1: The array holds 2^AddrW independent sixteen-bit words. A word written at one address, including the highest address, reads back unchanged after writes to other addresses.
- R2: While ceN is 1, both drvEn bits are 0 and standby is 1, whatever the other inputs are. While ceN is 0, standby is 0.
- R3: With ceN=0, weN=1 and oeN=0, drvEn[0] equals the inverse of lbN (lane bits 7:0) and drvEn[1] equals the inverse of ubN (lane bits 15:8). rdData always shows the word at addr, combinationally.
- R4: A write updates only the lanes whose enable was 0 in the last sample of the pulse. The other lane of that word keeps its old value.
- R5: While a write is active (ceN=0 and weN=0), drvEn is 00 and oeN has no effect on the write.
- R6: The array changes at the clock edge where the sampled ceN or weN first shows 1 after a sample with both at 0. The edge that ends the pulse can come from either pin. Before that edge the word keeps its old value.
- R7: The address, data and lane enables stored are those sampled in the last cycle with the write active. Values present at the end edge itself are ignored.
- R8: With ceN=0 and weN=1, drvEn is 00 when oeN is 1 or when lbN and ubN are both 1.
- R9: An active-low reset clears the write tracking. A pulse interrupted by reset commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of the write tracker |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| lbN | input | 1 | Lower byte lane enable (bits 7:0), active low |
| ubN | input | 1 | Upper byte lane enable (bits 15:8), active low |
| addr | input | AddrW | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Addressed word, combinational |
| drvEn | output | 2 | Per-lane output drive enable, bit 0 = lower lane |
| standby | output | 1 | High while chip select is inactive |

## Verification
The vector table tries full-word, lower-only and upper-only writes. Some pulses are closed by the write strobe and some by chip select, and oeN is held both high and low during a write. These patterns show whether lane gating and the choice of ending pin are handled apart. Read rows take every lane-enable combination, and the oeN and ceN states show that each lane's drive follows its own enable. A write whose data changes in the middle of the pulse separates last-sample capture from first-sample or end-edge capture. Directed cases cover the highest address and a pulse aborted by reset.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int DataW = 16;
  localparam int LaneW = 8;
  localparam int Lanes = DataW / LaneW;

  typedef struct packed {
    logic             commit;
    logic [Lanes-1:0] wrLane;
    logic [DataW-1:0] wrData;
  } ctrlStrobes_t;
endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 weN,
  input  logic                 oeN,
  input  logic [Lanes-1:0]     laneN,
  input  logic [AddrW-1:0]     addr,
  input  logic [DataW-1:0]     wrData,
  output ctrlStrobes_t         strb,
  output logic [AddrW-1:0]     heldAddr,
  output logic [Lanes-1:0]     drvEn
);
  logic writing;
  logic reading;
  logic wasWriting;
  logic [DataW-1:0] heldData;
  logic [Lanes-1:0] heldLaneN;

  assign writing = ~ceN & ~weN;
  assign reading = ~ceN & weN & ~oeN;

  // Sample the write while it is active; the last sample wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wasWriting <= 1'b0;
      heldAddr   <= '0;
      heldData   <= '0;
      heldLaneN  <= '1;
    end else begin
      wasWriting <= writing;
      if (writing) begin
        heldAddr  <= addr;
        heldData  <= wrData;
        heldLaneN <= laneN;
      end
    end
  end

  always_comb begin
    strb.commit = wasWriting & ~writing;
    strb.wrLane = ~heldLaneN;
    strb.wrData = heldData;
  end

  for (genvar g = 0; g < Lanes; g++) begin : g_drv
    assign drvEn[g] = reading & ~laneN[g];
  end

  // R5: no lane is driven while a write pulse is active
  p_quiet_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    writing |-> (drvEn == '0));

  // R7: captured write data is frozen once the pulse is inactive
  p_held_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !writing |=> $stable(heldData));
endmodule

// File: rtl/bls_store.sv
module bls_store
  import bls_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [AddrW-1:0] heldAddr,
  input  logic [AddrW-1:0] addr,
  output logic [DataW-1:0] rdData
);
  localparam int Depth = 1 << AddrW;

  logic [DataW-1:0] mem [Depth];

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int g = 0; g < Lanes; g++) begin
        if (strb.wrLane[g]) mem[heldAddr][g*LaneW +: LaneW] <= strb.wrData[g*LaneW +: LaneW];
      end
    end
  end

  assign rdData = mem[addr];

  // R4: an enabled lower lane holds the committed byte after the edge
  p_lane_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.wrLane[0]) |=>
      (mem[$past(heldAddr)][LaneW-1:0] == $past(strb.wrData[LaneW-1:0])));

  // R4: an enabled upper lane holds the committed byte after the edge
  p_lane_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.wrLane[1]) |=>
      (mem[$past(heldAddr)][DataW-1:LaneW] == $past(strb.wrData[DataW-1:LaneW])));
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import bls_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             oeN,
  input  logic             lbN,
  input  logic             ubN,
  input  logic [AddrW-1:0] addr,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  output logic [1:0]       drvEn,
  output logic             standby
);
  ctrlStrobes_t     strb;
  logic [AddrW-1:0] heldAddr;

  bls_ctrl #(.AddrW(AddrW)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .laneN({ubN, lbN}), .addr(addr), .wrData(wrData),
    .strb(strb), .heldAddr(heldAddr), .drvEn(drvEn)
  );

  bls_store #(.AddrW(AddrW)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb), .heldAddr(heldAddr),
    .addr(addr), .rdData(rdData)
  );

  assign standby = ceN;

  // R2: standby silences both lanes
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (drvEn == 2'b00));

  // R3: any driven lane implies a read state
  p_drive_needs_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn != 2'b00) |-> (!oeN && weN && !ceN));
endmodule

// File: tb/test_byte_lane_sram.sv
module test_byte_lane_sram;
  localparam int AW = 11;

  typedef struct packed {
    logic        ceN, weN, oeN, lbN, ubN;
    logic [10:0] a;
    logic [15:0] d;
    logic [1:0]  drv;
    logic        std;
    logic        chk;
    logic [15:0] q;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t Vecs [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 11'h010, 16'hA5C3, 2'b00, 1'b0, 1'b0, 16'h0000, 4'd5}, // R5 write full
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 11'h010, 16'h0000, 2'b00, 1'b0, 1'b1, 16'hA5C3, 4'd6}, // R6 end by weN
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 11'h010, 16'h0000, 2'b11, 1'b0, 1'b1, 16'hA5C3, 4'd3}, // R3 full read
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 11'h020, 16'h1234, 2'b00, 1'b0, 1'b0, 16'h0000, 4'd5}, // R5 oeN low in write
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 11'h020, 16'h0000, 2'b00, 1'b1, 1'b1, 16'h1234, 4'd6}, // R6 end by ceN
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 11'h020, 16'h0000, 2'b01, 1'b0, 1'b1, 16'h1234, 4'd3}, // R3 lower only
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 11'h020, 16'h0000, 2'b10, 1'b0, 1'b1, 16'h1234, 4'd3}, // R3 upper only
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 11'h020, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h1234, 4'd8}, // R8 no lanes
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 11'h020, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h1234, 4'd8}, // R8 oeN high
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 11'h010, 16'hFF77, 2'b00, 1'b0, 1'b1, 16'hA5C3, 4'd6}, // R6 not yet stored
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 11'h010, 16'h0066, 2'b00, 1'b0, 1'b1, 16'hA5C3, 4'd7}, // R7 data changes
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 11'h010, 16'h0011, 2'b01, 1'b0, 1'b1, 16'hA566, 4'd7}, // R7 R4 lower stored
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 11'h010, 16'hBB00, 2'b00, 1'b0, 1'b1, 16'hA566, 4'd5}, // R5 upper write
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 11'h010, 16'h0000, 2'b11, 1'b0, 1'b1, 16'hBB66, 4'd4}, // R4 upper stored
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 11'h020, 16'h0000, 2'b00, 1'b1, 1'b1, 16'h1234, 4'd2}, // R2 R1 standby
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 11'h010, 16'h0000, 2'b11, 1'b0, 1'b1, 16'hBB66, 4'd1}  // R1 other word
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lbN = 1'b1, ubN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  drvEn;
  logic        standby;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  byte_lane_sram #(.AddrW(AW)) i_byte_lane_sram (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .drvEn(drvEn), .standby(standby)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, w, o, l, u, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ceN = c; weN = w; oeN = o; lbN = l; ubN = u; addr = a; wrData = d;
    @(posedge clk);
    #5;
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R2: reset state with chip deselected
    check("R2 reset drvEn", {14'b0, drvEn}, 16'h0000);
    check("R2 reset standby", {15'b0, standby}, 16'h0001);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(Vecs[i].ceN, Vecs[i].weN, Vecs[i].oeN, Vecs[i].lbN, Vecs[i].ubN,
            Vecs[i].a[AW-1:0], Vecs[i].d);
      check($sformatf("R%0d row%0d drvEn", Vecs[i].req, i), {14'b0, drvEn}, {14'b0, Vecs[i].drv});
      check($sformatf("R%0d row%0d standby", Vecs[i].req, i), {15'b0, standby}, {15'b0, Vecs[i].std});
      if (Vecs[i].chk)
        check($sformatf("R%0d row%0d rdData", Vecs[i].req, i), rdData, Vecs[i].q);
    end

    // R1: highest address holds its own word
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '1, 16'h0F0F);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '1, 16'h0000);
    check("R1 top address", rdData, 16'h0F0F);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h010, 16'h0000);
    check("R1 low word intact", rdData, 16'hBB66);

    // R9: pulse interrupted by reset stores nothing
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h030, 16'h5555);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h030, 16'h0000);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h030, 16'hDEAD);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    weN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h030, 16'h0000);
    check("R9 aborted write", rdData, 16'h5555);
    check("R9 read lanes", {14'b0, drvEn}, 16'h0003);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule